// File: doc/BRIEF.md
# Bit-Sliced Triple-Port Register File with Rotated Address Decode

This block is a small register file with one write port and two independent read ports (called I and R). It is built from identical one-bit slices. Each of the 16 data slices holds one bit of every register. A seventeenth slice holds an even-parity bit for each register. Every slice has its own write decoder and its own pair of read multiplexer trees.

The trees are built as a chain of 2-way, 4-way and 8-way (and, in the larger variant, 16-way) selection levels. Each slice wires the shared address bits to those levels in a rotated order that depends on the slice index. Taken over the whole array, every address bit therefore drives a similar share of the selection load. The write decoder of a slice uses exactly the same rotation as that slice's read trees, so the rotation has no effect on which logical register is accessed.

Storage updates on the rising clock edge and reads are combinational. A write becomes visible in the cycle after its edge. Each read port returns the 16 data bits together with a flag that reports a parity mismatch. A write-side control bit stores deliberately inverted parity, so that error handling further down the datapath can be exercised.

Top module: `regfile_bitslice`

## Requirements
- R1: While the active-low reset is asserted, every register, including its parity bit, is cleared to zero. Reads after reset return 0 with the error flag low.
- R2: When `wr_en` is 1 at a rising edge, `wr_data` is stored in register `wr_addr`. From the next cycle on, both read ports return that value for that address.
- R3: A read of the address being written in the same cycle returns the value held before that edge.
- R4: The I and R read ports select their registers independently, and both are valid in the same cycle.
- R5: When `wr_en` is 0, no register changes, whatever `wr_addr`, `wr_data` and `wr_par_inv` carry.
- R6: On a write, the parity slice stores the XOR of the 16 data bits. A read port's error flag is the XOR of the 16 data bits it returns and the stored parity bit, so it is 0 for a normal write.
- R7: A write with `wr_par_inv` = 1 stores the inverted parity bit. Reads of that register then return the correct data with the error flag at 1, until a normal write to that register clears it.
- R8: The register count is 2**`ADDR_W`, with `ADDR_W` equal to 3 or 4. Every address selects its own register, with no aliasing between addresses.
- R9: Slice s, where s runs from 0 to 16 and the parity slice is 16, uses rotation r = (s / `ROT_STEP`) mod `ADDR_W`. Selection level k (k = 0 is the 2-way level) of both its write decoder and its read trees is driven by address bit (k + r) mod `ADDR_W`. The logical behaviour is identical for `ROT_STEP` of 1, 2 and 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W | Write register address |
| wr_data | input | DATA_W | Write data |
| wr_par_inv | input | 1 | Store inverted parity with this write (fault injection) |
| rdi_addr | input | ADDR_W | I read port address |
| rdr_addr | input | ADDR_W | R read port address |
| rdi_data | output | DATA_W | I read port data |
| rdi_perr | output | 1 | I read port parity mismatch |
| rdr_data | output | DATA_W | R read port data |
| rdr_perr | output | 1 | R read port parity mismatch |

## Verification
The embedded properties check, on every cycle, that each slice holds the bit written to the row chosen by its own rotated address. At the ports they check write-then-read agreement on both read ports, the absence of a parity flag after a clean write, its presence after an inverted-parity write, zero reads during reset, and unchanged read data across cycles with no write. Only the bench scenarios can show that the four rotation variants (steps 1, 2 and 4 with four address bits, and the three-bit variant) map every address to the same logical register with no aliasing. The same holds for the old-value read in the write cycle and for the recovery of a flagged register by a clean write. Those scenarios run random traffic against a plain array model.

// File: rtl/rfbs_pkg.sv
package rfbs_pkg;
  // Rotation applied inside slice idx: groups of 'step' slices share one order.
  function automatic int slice_rot(input int idx, input int step, input int aw);
    return (idx / step) % aw;
  endfunction
endpackage

// File: rtl/rfbs_mux_tree.sv
// Binary selection tree over 2**AW leaves, built heap-style: node n has
// children 2n+1 (select 0) and 2n+2 (select 1); the root is node 0.
// Depth d is steered by sel[AW-1-d], so sel[0] drives the 2-way level.
module rfbs_mux_tree #(
  parameter int AW = 3
) (
  input  logic [(1<<AW)-1:0] leaves,
  input  logic [AW-1:0]      sel,
  output logic               out
);
  localparam int N     = 1 << AW;
  localparam int NODES = 2 * N - 1;

  logic [NODES-1:0] node;

  genvar j, d, q;
  generate
    for (j = 0; j < N; j++) begin : g_leaf
      assign node[N - 1 + j] = leaves[j];
    end
    for (d = 0; d < AW; d++) begin : g_depth
      for (q = 0; q < (1 << d); q++) begin : g_node
        localparam int IDX = (1 << d) - 1 + q;
        assign node[IDX] = sel[AW-1-d] ? node[2*IDX+2] : node[2*IDX+1];
      end
    end
  endgenerate

  assign out = node[0];
endmodule

// File: rtl/rfbs_slice.sv
// One bit of every register, with a private write decoder and two read trees,
// all fed by the same rotated copy of the address bits.
module rfbs_slice #(
  parameter int AW  = 3,
  parameter int ROT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic [AW-1:0] rdi_addr,
  input  logic [AW-1:0] rdr_addr,
  output logic          rdi_bit,
  output logic          rdr_bit
);
  localparam int NREG = 1 << AW;

  logic [AW-1:0]   wr_p, rdi_p, rdr_p;
  logic [NREG-1:0] row_we;
  logic [NREG-1:0] mem_d, mem_q;

  // Level k takes logical address bit (k + ROT) mod AW (R9).
  genvar k;
  generate
    for (k = 0; k < AW; k++) begin : g_rot
      localparam int SRC = (k + ROT) % AW;
      assign wr_p[k]  = wr_addr[SRC];
      assign rdi_p[k] = rdi_addr[SRC];
      assign rdr_p[k] = rdr_addr[SRC];
    end
  endgenerate

  // Write decoder on the permuted address.
  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      row_we[r] = wr_en && (wr_p == AW'(r));
    end
  end

  // Next-state.
  always_comb begin
    mem_d = mem_q;
    for (int r = 0; r < NREG; r++) begin
      if (row_we[r]) mem_d[r] = wr_bit;
    end
  end

  // State, with the clock enable written out.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (wr_en) begin
      mem_q <= mem_d;
    end
  end

  rfbs_mux_tree #(.AW(AW)) u_tree_i (.leaves(mem_q), .sel(rdi_p), .out(rdi_bit));
  rfbs_mux_tree #(.AW(AW)) u_tree_r (.leaves(mem_q), .sel(rdr_p), .out(rdr_bit));

  // The physical row chosen by the rotated write address holds the bit.
  assert_slice_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(wr_p)] == $past(wr_bit));
endmodule

// File: rtl/regfile_bitslice.sv
module regfile_bitslice #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int ROT_STEP = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_par_inv,
  input  logic [ADDR_W-1:0] rdi_addr,
  input  logic [ADDR_W-1:0] rdr_addr,
  output logic [DATA_W-1:0] rdi_data,
  output logic              rdi_perr,
  output logic [DATA_W-1:0] rdr_data,
  output logic              rdr_perr
);
  import rfbs_pkg::*;

  localparam int NSLICE = DATA_W + 1;   // data slices plus the parity slice
  localparam int PAR    = DATA_W;

  logic [NSLICE-1:0] slice_wr, slice_i, slice_r;

  // Even parity on the write side; the inject bit flips it (R6, R7).
  assign slice_wr = {(^wr_data) ^ wr_par_inv, wr_data};

  genvar s;
  generate
    for (s = 0; s < NSLICE; s++) begin : g_slice
      rfbs_slice #(
        .AW (ADDR_W),
        .ROT(slice_rot(s, ROT_STEP, ADDR_W))
      ) u_slice (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_bit  (slice_wr[s]),
        .rdi_addr(rdi_addr),
        .rdr_addr(rdr_addr),
        .rdi_bit (slice_i[s]),
        .rdr_bit (slice_r[s])
      );
    end
  endgenerate

  assign rdi_data = slice_i[DATA_W-1:0];
  assign rdr_data = slice_r[DATA_W-1:0];
  assign rdi_perr = ^slice_i;
  assign rdr_perr = ^slice_r;

  // ---- port-level properties ----
  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |-> (rdi_data == '0 && rdr_data == '0 && !rdi_perr && !rdr_perr));

  assert_wr_read_i_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rdi_addr != $past(wr_addr)) || (rdi_data == $past(wr_data)));

  assert_wr_read_r_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rdr_addr != $past(wr_addr)) || (rdr_data == $past(wr_data)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (rdi_addr != $past(rdi_addr)) || $stable(rdi_data));

  assert_clean_par_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_par_inv) |=> (rdi_addr != $past(wr_addr)) || !rdi_perr);

  assert_inject_par_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_par_inv) |=> (rdr_addr != $past(wr_addr)) || rdr_perr);
endmodule

// File: tb/sim_regfile_bitslice.sv
module sim_regfile_bitslice;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_par_inv;
  logic [3:0]  wr_addr, rdi_addr, rdr_addr;
  logic [15:0] wr_data;

  logic [15:0] idat [4];
  logic [15:0] rdat [4];
  logic        ierr [4];
  logic        rerr [4];

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  // plain array models: 16-entry for the four-bit variants, 8-entry for u3
  logic [15:0] m4  [16];
  logic        m4b [16];
  logic [15:0] m3  [8];
  logic        m3b [8];

  always #4 clk = ~clk;   // 125 MHz

  regfile_bitslice #(.ADDR_W(4), .ROT_STEP(1)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_par_inv(wr_par_inv), .rdi_addr(rdi_addr), .rdr_addr(rdr_addr),
    .rdi_data(idat[0]), .rdi_perr(ierr[0]), .rdr_data(rdat[0]), .rdr_perr(rerr[0]));
  regfile_bitslice #(.ADDR_W(4), .ROT_STEP(2)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_par_inv(wr_par_inv), .rdi_addr(rdi_addr), .rdr_addr(rdr_addr),
    .rdi_data(idat[1]), .rdi_perr(ierr[1]), .rdr_data(rdat[1]), .rdr_perr(rerr[1]));
  regfile_bitslice #(.ADDR_W(4), .ROT_STEP(4)) u2 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_par_inv(wr_par_inv), .rdi_addr(rdi_addr), .rdr_addr(rdr_addr),
    .rdi_data(idat[2]), .rdi_perr(ierr[2]), .rdr_data(rdat[2]), .rdr_perr(rerr[2]));
  regfile_bitslice #(.ADDR_W(3), .ROT_STEP(1)) u3 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr[2:0]), .wr_data(wr_data),
    .wr_par_inv(wr_par_inv), .rdi_addr(rdi_addr[2:0]), .rdr_addr(rdr_addr[2:0]),
    .rdi_data(idat[3]), .rdi_perr(ierr[3]), .rdr_data(rdat[3]), .rdr_perr(rerr[3]));

  task automatic chk(input string tag, input int inst, input logic [16:0] act,
                     input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s u%0d: actual perr/data=%h expected=%h", tag, inst, act, exp);
    end
  endtask

  // One cycle: drive after the falling edge, compare before the rising edge,
  // then update the models at the rising edge.
  task automatic cyc(input logic we, input logic [3:0] wa, input logic [15:0] wd,
                     input logic inv, input logic [3:0] ia, input logic [3:0] ra,
                     input string tag);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; wr_par_inv = inv;
    rdi_addr = ia; rdr_addr = ra;
    #2;
    for (int u = 0; u < 3; u++) begin
      chk({tag, " port I"}, u, {ierr[u], idat[u]}, {m4b[ia], m4[ia]});
      chk({tag, " port R"}, u, {rerr[u], rdat[u]}, {m4b[ra], m4[ra]});
    end
    chk({tag, " port I"}, 3, {ierr[3], idat[3]}, {m3b[ia[2:0]], m3[ia[2:0]]});
    chk({tag, " port R"}, 3, {rerr[3], rdat[3]}, {m3b[ra[2:0]], m3[ra[2:0]]});
    @(posedge clk);
    if (we) begin
      m4[wa] = wd;       m4b[wa] = inv;
      m3[wa[2:0]] = wd;  m3b[wa[2:0]] = inv;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_0b17;
    void'($urandom(seed));
    for (int a = 0; a < 16; a++) begin m4[a] = '0; m4b[a] = 1'b0; end
    for (int a = 0; a < 8; a++)  begin m3[a] = '0; m3b[a] = 1'b0; end
    rst_n = 1'b0; wr_en = 1'b0; wr_par_inv = 1'b0;
    wr_addr = '0; wr_data = '0; rdi_addr = '0; rdr_addr = '0;
    repeat (3) @(posedge clk);
    // R1: reads during reset are zero; a write attempt is blocked by reset
    @(negedge clk);
    wr_en = 1'b1; wr_data = 16'hFFFF; rdi_addr = 4'd7; rdr_addr = 4'd9;
    #2;
    chk("R1 in reset", 0, {ierr[0], idat[0]}, 17'h0);
    chk("R1 in reset", 3, {rerr[3], rdat[3]}, 17'h0);
    wr_en = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    // R1: every address reads zero after reset
    for (int a = 0; a < 16; a++) cyc(1'b0, 4'(a), 16'hDEAD, 1'b0, 4'(a), 4'(15 - a), "R1 after reset");

    // R8: distinct value in every register, then read them all back
    for (int a = 0; a < 16; a++) cyc(1'b1, 4'(a), 16'(a * 16'h1111 ^ 16'h0F0F), 1'b0, 4'(a), 4'(a), "R8 fill");
    for (int a = 0; a < 16; a++) cyc(1'b0, 4'd0, 16'h0, 1'b0, 4'(a), 4'(a ^ 5), "R8 readback");

    // R3: same-address read during a write returns the old value, R2 new value next
    cyc(1'b1, 4'd5, 16'hA5C3, 1'b0, 4'd5, 4'd5, "R3 read during write");
    cyc(1'b0, 4'd0, 16'h0,    1'b0, 4'd5, 4'd5, "R2 visible next cycle");

    // R5: disabled write with active-looking inputs changes nothing
    cyc(1'b0, 4'd6, 16'h1234, 1'b1, 4'd6, 4'd6, "R5 no write");
    cyc(1'b0, 4'd0, 16'h0,    1'b0, 4'd6, 4'd6, "R5 unchanged");

    // R6: odd-weight and even-weight data read with clean parity
    cyc(1'b1, 4'd9, 16'h0001, 1'b0, 4'd0, 4'd1, "R6 odd data");
    cyc(1'b1, 4'd10, 16'h0003, 1'b0, 4'd9, 4'd9, "R6 odd data clean flag");
    cyc(1'b0, 4'd0, 16'h0,    1'b0, 4'd10, 4'd9, "R6 even data clean flag");

    // R7: inverted parity flags the register on both ports, clean write clears
    cyc(1'b1, 4'd3, 16'h7E81, 1'b1, 4'd0, 4'd0, "R7 inject");
    cyc(1'b0, 4'd0, 16'h0,    1'b0, 4'd3, 4'd3, "R7 flag raised");
    cyc(1'b1, 4'd3, 16'h7E81, 1'b0, 4'd3, 4'd2, "R7 flag held in write cycle");
    cyc(1'b0, 4'd0, 16'h0,    1'b0, 4'd3, 4'd3, "R7 flag cleared");

    // R4 / R9: random traffic on independent ports across every rotation variant
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] rv;
      rv = $urandom;
      cyc(rv[0] | rv[1], rv[5:2], $urandom, (rv[9:6] == 4'd0), rv[13:10], rv[17:14],
          "R9 R4 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule